// File: doc/BRIEF.md
# Prioritized Reset Cause Register

This block keeps a record of why the system last went through reset. It watches five reset sources:

- power-on reset, which is active low and asynchronous;
- the external reset pin, which is active low and asynchronous to the clock;
- a watchdog loss-of-reference request;
- a watchdog CPU time-out request;
- a software reset request.

It stores the winning cause as a single flag in a 16-bit read-only status word. Power-on reset forces the word to the power-on value at once. After power-on ends, the word is rewritten on every clock edge where at least one of the other four sources is active. The highest-priority active source always wins, and the new flag replaces the old one completely. When no source is active, the word holds its value.

The pin is synchronized through a flop chain before it is used. If the pin is still low when power-on reset releases, the power-on flag is replaced by the external flag. The block also drives a vector-select output. Boot logic uses it to start from the watchdog vector when a watchdog flag is set, and from the normal vector otherwise.

Top module: `rst_cause_unit`

## Requirements
- R1: While `por_n` is low, `status_word` reads 0x0004 (bit 2, power-on). This takes effect without waiting for a clock edge and overrides every other source.
- R2: Exactly one of bits 6..2 of `status_word` is ever set. Bits 15..7 and 1..0 always read 0.
- R3: When several sources are active together, only the highest-priority one is recorded. The order is external pin (bit 3, 0x0008), then watchdog loss-of-reference (bit 4, 0x0010), then watchdog CPU time-out (bit 5, 0x0020).
- R4: If `ext_pin_n` is low when `por_n` releases, the word changes from 0x0004 to 0x0008 once the synchronizer has passed the pin level.
- R5: If `ext_pin_n` is high at power-on release and no other source is active, the word stays 0x0004. A pin pulse that ends while `por_n` is still low leaves no trace.
- R6: A low level on `ext_pin_n` reaches the word on the third rising edge after it is applied. The watchdog and software inputs reach the word on the first rising edge.
- R7: With no source active, the word holds its value. A later cause replaces the stored flag completely.
- R8: `wdog_vec_sel` is 1 exactly when bit 4 or bit 5 of the word is set.
- R9: The software flag (bit 6, 0x0040) is recorded only when `sw_req` is the only active source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_pin_n | input | 1 | External reset pin level, active low, asynchronous |
| wdog_lor | input | 1 | Watchdog loss-of-reference reset request, active high |
| wdog_cpu | input | 1 | Watchdog CPU time-out reset request, active high |
| sw_req | input | 1 | Software reset request, active high |
| status_word | output | 16 | Read-only reset cause word |
| wdog_vec_sel | output | 1 | 1 selects the watchdog reset vector, 0 the normal vector |

## Verification
The bench steps through all sixteen combinations of the four post-power-on sources. Before each combination it stores a single-source cause, so that three cases can be told apart: a combination that must be recorded, the highest-priority member winning, and the all-idle combination that must leave the earlier cause in place. Power-on sequences with the pin held across the release, pulsed only inside reset, or with a watchdog request crossing the release separate the handoff rule from the plain power-on case. Edge-counted probes of the pin and of a watchdog input tell the synchronized path from the direct one. Asserting power-on in mid-cycle shows that it overrides at once.

// File: rtl/rcu_pkg.sv
// Package: shared constants for the reset cause unit.
// Assumes the four post-power-on sources occupy contiguous status bits
// starting at SRC_BASE, ordered from highest to lowest priority.
package rcu_pkg;
    localparam int WORD_W   = 16;
    localparam int NSRC     = 4;   // ext, lor, cpu, sw
    localparam int BIT_POR  = 2;
    localparam int SRC_BASE = 3;   // bit of the highest-priority source
    localparam int BIT_LOR  = SRC_BASE + 1;
    localparam int BIT_CPU  = SRC_BASE + 2;
    localparam logic [WORD_W-1:0] POR_WORD = WORD_W'(1) << BIT_POR;
endpackage

// File: rtl/rcu_sync.sv
// Module: multi-stage level synchronizer for one asynchronous input.
// Assumes the input is a slow level. Flops load RST_VAL while rst_n is low.
module rcu_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rcu_prio.sv
// Module: fixed-priority resolver. Index 0 has the highest priority.
// Produces a one-hot grant and an any-active flag. Purely combinational.
module rcu_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N-1:0] blocked;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_lane
            if (i == 0) begin : g_top
                // Highest-priority lane is never blocked.
                assign blocked[i] = 1'b0;
            end else begin : g_rest
                // Lane is blocked if any higher-priority lane requests.
                assign blocked[i] = blocked[i-1] | req[i-1];
            end
            assign grant[i] = req[i] & ~blocked[i];
        end
    endgenerate

    assign any = |req;
endmodule

// File: rtl/rcu_status.sv
// Module: cause status register and vector select.
// Async-loads the power-on word while por_n is low. Otherwise it is rewritten
// from the one-hot grant on any active cycle and held when idle.
module rcu_status
    import rcu_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [N-1:0]      grant,
    input  logic              any,
    output logic [WORD_W-1:0] word,
    output logic              vec_sel
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] next_word;

    // Place the granted source at its status bit; all other bits stay zero.
    always_comb begin
        next_word = '0;
        for (int k = 0; k < N; k++) next_word[SRC_BASE + k] = grant[k];
    end

    // Record the cause: power-on clears asynchronously, sources update synchronously.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)   word_q <= POR_WORD;
        else if (any) word_q <= next_word;
    end

    assign word    = word_q;
    assign vec_sel = word_q[BIT_LOR] | word_q[BIT_CPU];
endmodule

// File: rtl/rst_cause_unit.sv
// Module: top of the reset cause unit.
// Synchronizes the external pin, resolves source priority and holds the cause word.
// Assumes the watchdog and software requests are already in the clk domain.
module rst_cause_unit
    import rcu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_pin_n,
    input  logic              wdog_lor,
    input  logic              wdog_cpu,
    input  logic              sw_req,
    output logic [WORD_W-1:0] status_word,
    output logic              wdog_vec_sel
);
    logic            ext_pin_s;
    logic            ext_act;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;
    logic            any;

    rcu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .d_async (ext_pin_n),
        .q_sync  (ext_pin_s)
    );

    assign ext_act = ~ext_pin_s;
    assign req     = {sw_req, wdog_cpu, wdog_lor, ext_act};

    rcu_prio #(.N(NSRC)) u_prio (
        .req   (req),
        .grant (grant),
        .any   (any)
    );

    rcu_status #(.N(NSRC)) u_status (
        .clk     (clk),
        .por_n   (por_n),
        .grant   (grant),
        .any     (any),
        .word    (status_word),
        .vec_sel (wdog_vec_sel)
    );
endmodule

// File: rtl/rcu_checker.sv
// Module: protocol checker for rst_cause_unit, attached by bind.
// Relates the source inputs and the synchronized pin to the cause word.
module rcu_checker (
    input logic        clk,
    input logic        por_n,
    input logic        ext_act,
    input logic        wdog_lor,
    input logic        wdog_cpu,
    input logic        sw_req,
    input logic [15:0] status_word,
    input logic        wdog_vec_sel
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (!por_n)
        ($countones(status_word[6:2]) == 1) && (status_word[15:7] == '0) && (status_word[1:0] == '0));

    p_ext_wins_r3: assert property (@(posedge clk) disable iff (!por_n)
        ext_act |=> status_word == 16'h0008);

    p_lor_over_cpu_r3: assert property (@(posedge clk) disable iff (!por_n)
        (wdog_lor && !ext_act) |=> status_word == 16'h0010);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!ext_act && !wdog_lor && !wdog_cpu && !sw_req) |=> $stable(status_word));

    p_sw_alone_r9: assert property (@(posedge clk) disable iff (!por_n)
        (sw_req && !ext_act && !wdog_lor && !wdog_cpu) |=> status_word == 16'h0040);

    p_wdog_vec_r8: assert property (@(posedge clk) disable iff (!por_n)
        (status_word[4] || status_word[5]) |-> wdog_vec_sel);

    p_norm_vec_r8: assert property (@(posedge clk) disable iff (!por_n)
        (status_word[2] || status_word[3] || status_word[6]) |-> !wdog_vec_sel);
endmodule

bind rst_cause_unit rcu_checker u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .ext_act      (ext_act),
    .wdog_lor     (wdog_lor),
    .wdog_cpu     (wdog_cpu),
    .sw_req       (sw_req),
    .status_word  (status_word),
    .wdog_vec_sel (wdog_vec_sel)
);

// File: tb/tb_rst_cause_unit.sv
// Bench: sweeps every combination of the post-power-on sources, plus
// power-on handoff and latency probes. Expected words are computed arithmetically.
module tb_rst_cause_unit;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_pin_n = 1'b1;
    logic        wdog_lor = 1'b0;
    logic        wdog_cpu = 1'b0;
    logic        sw_req = 1'b0;
    logic [15:0] status_word;
    logic        wdog_vec_sel;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] expw;

    rst_cause_unit dut (
        .clk          (clk),
        .por_n        (por_n),
        .ext_pin_n    (ext_pin_n),
        .wdog_lor     (wdog_lor),
        .wdog_cpu     (wdog_cpu),
        .sw_req       (sw_req),
        .status_word  (status_word),
        .wdog_vec_sel (wdog_vec_sel)
    );

    always #4 clk = ~clk;

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Word, vector select (R8) and one-hot shape (R2) against one expected word.
    task automatic chkword(input string tag, input logic [15:0] exp);
        chk16(tag, status_word, exp);
        chk16({"R8 vector select, ", tag}, {15'd0, wdog_vec_sel}, {15'd0, exp[4] | exp[5]});
        chk16({"R2 one-hot, ", tag},
              {12'd0, 4'($countones(status_word[6:2]))} | (status_word & 16'hFF83), 16'h0001);
    endtask

    // c[0]=ext pin, c[1]=loss-of-reference, c[2]=CPU time-out, c[3]=software.
    task automatic drive(input logic [3:0] c);
        ext_pin_n = ~c[0];
        wdog_lor  = c[1];
        wdog_cpu  = c[2];
        sw_req    = c[3];
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // The lowest set index wins; with nothing set the previous word is kept.
    function automatic logic [15:0] model(input logic [3:0] c, input logic [15:0] prev);
        logic [15:0] r = prev;
        for (int i = 3; i >= 0; i--) if (c[i]) r = 16'h0008 << i;
        return r;
    endfunction

    initial begin
        #(8 * 100000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state, with every source active while power-on is held.
        cyc(2);
        chkword("R1 reset state", 16'h0004);
        drive(4'b1111);
        cyc(4);
        chkword("R1 power-on overrides all sources", 16'h0004);
        drive(4'b0000);
        cyc(4);
        por_n = 1'b1;
        cyc(5);
        chkword("R5 clean release keeps power-on", 16'h0004);

        // R3, R7, R9: every combination, each after a known single-source cause.
        expw = 16'h0004;
        for (int c = 0; c < 16; c++) begin
            int p = c % 4;
            drive(4'b0001 << p);
            cyc(4);
            drive(4'b0000);
            cyc(4);
            expw = 16'h0008 << p;
            chkword("R7 single cause replaces previous", expw);
            drive(c[3:0]);
            cyc(4);
            drive(4'b0000);
            cyc(4);
            expw = model(c[3:0], expw);
            if (c == 8)      chkword("R9 software alone", expw);
            else if (c == 0) chkword("R7 idle holds", expw);
            else             chkword("R3 priority combination", expw);
        end

        // R6: pin latency is three rising edges; software and watchdog take one.
        sw_req = 1'b1;
        cyc(1);
        chkword("R6 software one edge", 16'h0040);
        sw_req = 1'b0;
        cyc(3);
        ext_pin_n = 1'b0;
        cyc(2);
        chkword("R6 pin not yet at two edges", 16'h0040);
        cyc(1);
        chkword("R6 pin at third edge", 16'h0008);
        ext_pin_n = 1'b1;
        cyc(4);
        wdog_cpu = 1'b1;
        cyc(1);
        chkword("R6 watchdog one edge", 16'h0020);
        wdog_cpu = 1'b0;
        cyc(2);

        // R1: power-on takes effect in mid-cycle, before any clock edge.
        #1 por_n = 1'b0;
        #1 chkword("R1 asynchronous power-on", 16'h0004);

        // R4: pin held low across the power-on release.
        cyc(1);
        ext_pin_n = 1'b0;
        cyc(3);
        chkword("R4 pin low during power-on", 16'h0004);
        por_n = 1'b1;
        cyc(1);
        chkword("R4 before synchronizer", 16'h0004);
        cyc(3);
        chkword("R4 handoff to external", 16'h0008);
        ext_pin_n = 1'b1;
        cyc(4);
        chkword("R7 held after pin release", 16'h0008);

        // R5: pin pulse ending inside power-on leaves power-on recorded.
        por_n = 1'b0;
        cyc(1);
        ext_pin_n = 1'b0;
        cyc(3);
        ext_pin_n = 1'b1;
        cyc(2);
        por_n = 1'b1;
        cyc(5);
        chkword("R5 pulse inside power-on", 16'h0004);

        // R3: watchdog request crossing the release, with the pin also held.
        por_n = 1'b0;
        cyc(1);
        wdog_lor = 1'b1;
        ext_pin_n = 1'b0;
        cyc(2);
        por_n = 1'b1;
        cyc(1);
        chkword("R3 watchdog before pin is synchronized", 16'h0010);
        cyc(3);
        chkword("R3 pin overtakes watchdog", 16'h0008);
        drive(4'b0000);
        cyc(4);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule